// File: doc/BRIEF.md
# GPIO Pad Resolution Bank

This block holds the configuration of a bank of general-purpose pins and works out, for every pin, the level its pad settles at and the value software reads back as input. Each pin is set by seven bits: the value to drive, whether the driver is on, whether the driver is push-pull or open-drain, an inversion bit, a pull-up bit, a pull-down bit and an input gate. The pad is modelled inside the block, so there is no tristate at the boundary. A pad that nothing drives takes its level from the pull settings.

Software reaches the bank through a simple word-wide write strobe and a combinational read port. The drive-value and driver-enable registers each also have two extra addresses. Writing a 1 to a bit at one of these addresses sets that bit, and writing a 1 at the other clears it. This lets one pin be changed without a read-modify-write. The inversion bit is applied on the way out and again on the way in. As a result, a push-pull pin always reads back what was written to it. The resolved pad levels and the input value are also available as ports, for use by the rest of the chip.

Top module: `gpio_pad_bank`

## Requirements
- R1: An active-low asynchronous reset loads inversion, drive value, driver enable and driver type with all zeros, pull-up with all ones, pull-down with zeros and input gate with all ones.
- R2: A write with `bus_we` high stores `bus_wdata` at the clock edge in the register at that byte address: inversion 0x08, drive value 0x0C, driver enable 0x10, driver type 0x14 (1 = open-drain), pull-up 0x1C, pull-down 0x20, input gate 0x58. A read at the same address returns the stored word.
- R3: A write to 0x68 sets the drive-value bits where the data is 1, and a write to 0x70 does the same for driver enable. Bits written as 0 are unchanged.
- R4: A write to 0x6C clears the drive-value bits where the data is 1, and a write to 0x74 does the same for driver enable. Bits written as 0 are unchanged.
- R5: A pin with driver enable set and driver type 0 has a pad level equal to drive value XOR inversion. Its pull bits have no effect.
- R6: A pin with driver enable clear has a pad level of 1 only when pull-up is 1 and pull-down is 0; otherwise its pad level is 0. Drive value and driver type have no effect.
- R7: A pin with driver enable set and driver type 1 has a pad level of 0 when drive value XOR inversion is 0. Otherwise its pad level follows the R6 pull rule.
- R8: For each pin, the input value is (pad AND input gate) XOR inversion. A gated-off pin therefore reads its inversion bit.
- R9: Address 0x04 returns the input value, which equals the `data_in` port. Writes to 0x04 change no register.
- R10: A push-pull driven pin with its input gate open reads back its drive value, whatever its inversion bit.
- R11: Reads at any address not listed in R2 or R9 return zero, and that includes the set and clear addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (7) | Byte address of the access |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Combinational read data at `bus_addr` |
| data_in | output | NPINS (32) | Per-pin input value |
| pad_level | output | NPINS (32) | Resolved level of each pad |

## Verification
A configuration bit stored wrongly, or a set or clear address that hits the wrong register, shows on the read port at the next falling edge after the write. Because the pad and input paths are combinational from the stored bits, it also shows on `pad_level` or `data_in` in that same cycle. The sweep gives every pin a different one of the 128 seven-bit configurations over four passes. A wrong branch in the per-pin resolution therefore shows up as a mismatch on a known bit within one pass, and a swapped or dropped inversion term shows up on `data_in`.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    // Configuration register indices
    localparam int CFG_POL  = 0;
    localparam int CFG_DOUT = 1;
    localparam int CFG_OE   = 2;
    localparam int CFG_OTYP = 3;
    localparam int CFG_PU   = 4;
    localparam int CFG_PD   = 5;
    localparam int CFG_IE   = 6;
    localparam int NCFG     = 7;

    // Byte address of the read-only input value
    localparam int unsigned OFS_DIN = 32'h04;

    function automatic int unsigned cfg_offset(input int idx);
        case (idx)
            CFG_POL:  return 32'h08;
            CFG_DOUT: return 32'h0C;
            CFG_OE:   return 32'h10;
            CFG_OTYP: return 32'h14;
            CFG_PU:   return 32'h1C;
            CFG_PD:   return 32'h20;
            default:  return 32'h58;
        endcase
    endfunction

    function automatic bit cfg_rst_ones(input int idx);
        return (idx == CFG_PU) || (idx == CFG_IE);
    endfunction

    function automatic bit cfg_has_alias(input int idx);
        return (idx == CFG_DOUT) || (idx == CFG_OE);
    endfunction

    function automatic int unsigned cfg_set_offset(input int idx);
        return (idx == CFG_DOUT) ? 32'h68 : 32'h70;
    endfunction

    function automatic int unsigned cfg_clr_offset(input int idx);
        return (idx == CFG_DOUT) ? 32'h6C : 32'h74;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pad_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] cfg_q [NCFG]
);

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam logic [AW-1:0]    A_WR = AW'(cfg_offset(g));
        localparam logic [NPINS-1:0] RSTV = cfg_rst_ones(g) ? {NPINS{1'b1}} : '0;

        logic             hit_wr;
        logic             hit_set;
        logic             hit_clr;
        logic [NPINS-1:0] q_r;
        logic [NPINS-1:0] q_nxt;

        assign hit_wr = we && (addr == A_WR);

        if (cfg_has_alias(g)) begin : g_alias
            localparam logic [AW-1:0] A_SET = AW'(cfg_set_offset(g));
            localparam logic [AW-1:0] A_CLR = AW'(cfg_clr_offset(g));
            assign hit_set = we && (addr == A_SET);
            assign hit_clr = we && (addr == A_CLR);
        end else begin : g_plain
            assign hit_set = 1'b0;
            assign hit_clr = 1'b0;
        end

        always_comb begin
            q_nxt = q_r;
            if (hit_wr) begin
                q_nxt = wdata;
            end else if (hit_set) begin
                q_nxt = q_r | wdata;
            end else if (hit_clr) begin
                q_nxt = q_r & ~wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= RSTV;
            end else begin
                q_r <= q_nxt;
            end
        end

        assign cfg_q[g] = q_r;
    end

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve (
    input  logic pol,
    input  logic dout,
    input  logic oe,
    input  logic otyp,
    input  logic pu,
    input  logic pd,
    input  logic ie,
    output logic pad,
    output logic din
);

    logic drive_val;
    logic pull_lvl;

    always_comb begin
        drive_val = dout ^ pol;
        // Only an unambiguous pull-up gives a high; conflict or float reads low
        pull_lvl  = pu & ~pd;
        if (!oe) begin
            pad = pull_lvl;
        end else if (!otyp) begin
            pad = drive_val;
        end else begin
            pad = drive_val ? pull_lvl : 1'b0;
        end
        din = (pad & ie) ^ pol;
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pad_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 7
) (
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] cfg_q [NCFG],
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_DIN)) begin
            rdata = din;
        end
        for (int k = 0; k < NCFG; k++) begin
            if (addr == AW'(cfg_offset(k))) begin
                rdata = cfg_q[k];
            end
        end
    end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic [NPINS-1:0] data_in,
    output logic [NPINS-1:0] pad_level
);

    logic [NPINS-1:0] cfg_q [NCFG];
    logic [NPINS-1:0] r_pol;
    logic [NPINS-1:0] r_dout;
    logic [NPINS-1:0] r_oe;
    logic [NPINS-1:0] r_otyp;
    logic [NPINS-1:0] r_pu;
    logic [NPINS-1:0] r_pd;
    logic [NPINS-1:0] r_ie;

    gpio_cfg_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg_q (cfg_q)
    );

    assign r_pol  = cfg_q[CFG_POL];
    assign r_dout = cfg_q[CFG_DOUT];
    assign r_oe   = cfg_q[CFG_OE];
    assign r_otyp = cfg_q[CFG_OTYP];
    assign r_pu   = cfg_q[CFG_PU];
    assign r_pd   = cfg_q[CFG_PD];
    assign r_ie   = cfg_q[CFG_IE];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_resolve u_pin (
            .pol  (r_pol[p]),
            .dout (r_dout[p]),
            .oe   (r_oe[p]),
            .otyp (r_otyp[p]),
            .pu   (r_pu[p]),
            .pd   (r_pd[p]),
            .ie   (r_ie[p]),
            .pad  (pad_level[p]),
            .din  (data_in[p])
        );
    end

    gpio_read_mux #(.NPINS(NPINS), .AW(AW)) u_rmux (
        .addr  (bus_addr),
        .cfg_q (cfg_q),
        .din   (data_in),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
    parameter int NPINS = 32,
    parameter int AW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] data_in,
    input logic [NPINS-1:0] pad_level,
    input logic [NPINS-1:0] r_pol,
    input logic [NPINS-1:0] r_dout,
    input logic [NPINS-1:0] r_oe,
    input logic [NPINS-1:0] r_otyp,
    input logic [NPINS-1:0] r_pu,
    input logic [NPINS-1:0] r_pd,
    input logic [NPINS-1:0] r_ie
);

    // R2: a plain write to the inversion address lands on the next cycle
    a_r2_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(32'h08)) |=> (r_pol == $past(bus_wdata)));

    // R3: set alias raises every requested drive-value bit
    a_r3_dout_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(32'h68)) |=> ((r_dout & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: clear alias drops every requested driver-enable bit
    a_r4_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(32'h74)) |=> ((r_oe & $past(bus_wdata)) == '0));

    // R5: push-pull driven pads carry drive value XOR inversion
    a_r5_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_level ^ r_dout ^ r_pol) & r_oe & ~r_otyp) == '0);

    // R7: open-drain pins driving a 0 never show a high pad
    a_r7_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_level & r_oe & r_otyp & ~(r_dout ^ r_pol)) == '0);

    // R8: gated-off inputs read their inversion bit
    a_r8_masked_reads_pol: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_in ^ r_pol) & ~r_ie) == '0);

    // R9: writes to the input address leave every register unchanged
    a_r9_din_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(32'h04)) |=>
            $stable({r_pol, r_dout, r_oe, r_otyp, r_pu, r_pd, r_ie}));

endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .data_in   (data_in),
    .pad_level (pad_level),
    .r_pol     (r_pol),
    .r_dout    (r_dout),
    .r_oe      (r_oe),
    .r_otyp    (r_otyp),
    .r_pu      (r_pu),
    .r_pd      (r_pd),
    .r_ie      (r_ie)
);

// File: tb/tb_gpio_pad_bank.sv
module tb_gpio_pad_bank;

    localparam int N  = 32;
    localparam int AW = 7;

    localparam logic [AW-1:0] A_DIN  = 7'h04;
    localparam logic [AW-1:0] A_POL  = 7'h08;
    localparam logic [AW-1:0] A_DOUT = 7'h0C;
    localparam logic [AW-1:0] A_OE   = 7'h10;
    localparam logic [AW-1:0] A_OTYP = 7'h14;
    localparam logic [AW-1:0] A_PU   = 7'h1C;
    localparam logic [AW-1:0] A_PD   = 7'h20;
    localparam logic [AW-1:0] A_IE   = 7'h58;
    localparam logic [AW-1:0] A_DSET = 7'h68;
    localparam logic [AW-1:0] A_DCLR = 7'h6C;
    localparam logic [AW-1:0] A_OSET = 7'h70;
    localparam logic [AW-1:0] A_OCLR = 7'h74;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  data_in;
    logic [N-1:0]  pad_level;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    gpio_pad_bank #(.NPINS(N), .AW(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .data_in   (data_in),
        .pad_level (pad_level)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Expected pad per the requirements (R5, R6, R7)
    function automatic logic [N-1:0] exp_pad(input logic [N-1:0] pol, dout, oe, otyp, pu, pd);
        logic [N-1:0] drv;
        logic [N-1:0] pull;
        drv  = dout ^ pol;
        pull = pu & ~pd;
        return (~oe & pull) | (oe & ~otyp & drv) | (oe & otyp & drv & pull);
    endfunction

    task automatic load_all(input logic [N-1:0] pol, dout, oe, otyp, pu, pd, ie);
        wr(A_POL, pol);
        wr(A_DOUT, dout);
        wr(A_OE, oe);
        wr(A_OTYP, otyp);
        wr(A_PU, pu);
        wr(A_PD, pd);
        wr(A_IE, ie);
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] pv;

        repeat (3) @(negedge clk);

        // R1: reset contents and the pads they imply
        rd(A_POL, v);  chk("R1 inversion reset", v, '0);
        rd(A_DOUT, v); chk("R1 drive reset", v, '0);
        rd(A_OE, v);   chk("R1 enable reset", v, '0);
        rd(A_OTYP, v); chk("R1 type reset", v, '0);
        rd(A_PU, v);   chk("R1 pull-up reset", v, '1);
        rd(A_PD, v);   chk("R1 pull-down reset", v, '0);
        rd(A_IE, v);   chk("R1 input gate reset", v, '1);
        chk("R1 reset pads", pad_level, '1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: pin i in pass r holds configuration code r*32+i (all 128 codes)
        for (int r = 0; r < 4; r++) begin
            logic [N-1:0] s_pol, s_dout, s_oe, s_otyp, s_pu, s_pd, s_ie;
            logic [N-1:0] e_pad, e_din, m_pp, m_ud, m_od;
            for (int i = 0; i < N; i++) begin
                logic [6:0] c;
                c = 7'(r * 32 + i);
                s_pol[i]  = c[0];
                s_dout[i] = c[1];
                s_oe[i]   = c[2];
                s_otyp[i] = c[3];
                s_pu[i]   = c[4];
                s_pd[i]   = c[5];
                s_ie[i]   = c[6];
            end
            load_all(s_pol, s_dout, s_oe, s_otyp, s_pu, s_pd, s_ie);
            e_pad = exp_pad(s_pol, s_dout, s_oe, s_otyp, s_pu, s_pd);
            e_din = (e_pad & s_ie) ^ s_pol;
            m_pp  = s_oe & ~s_otyp;
            m_ud  = ~s_oe;
            m_od  = s_oe & s_otyp;
            rd(A_POL, v);  chk("R2 inversion readback", v, s_pol);
            rd(A_DOUT, v); chk("R2 drive readback", v, s_dout);
            rd(A_OE, v);   chk("R2 enable readback", v, s_oe);
            rd(A_OTYP, v); chk("R2 type readback", v, s_otyp);
            rd(A_PU, v);   chk("R2 pull-up readback", v, s_pu);
            rd(A_PD, v);   chk("R2 pull-down readback", v, s_pd);
            rd(A_IE, v);   chk("R2 gate readback", v, s_ie);
            chk("R5 push-pull pads", pad_level & m_pp, e_pad & m_pp);
            chk("R6 undriven pads", pad_level & m_ud, e_pad & m_ud);
            chk("R7 open-drain pads", pad_level & m_od, e_pad & m_od);
            chk("R8 input value", data_in, e_din);
            rd(A_DIN, v);  chk("R9 input via bus", v, e_din);
        end

        // R6: pulls alone, drive value and type irrelevant
        load_all('0, 32'hFFFF0000, '0, 32'h0F0F0F0F, 32'h23456789, ~32'h23456789, '1);
        chk("R6 pulls decide", pad_level, 32'h23456789);

        // R7: mixed open-drain pattern
        load_all('0, 32'hFFFF0000, 32'hF0F0F0F0, 32'h456789AB, 32'hFF00FF00, 32'h00FF00FF, '1);
        chk("R7 open-drain mix", data_in, 32'hFF900F00);

        // R7 with inversion: open-drain across all pins
        load_all('1, 32'hFF00FF00, '1, '1, 32'hFFFF0000, 32'h0000FFFF, '1);
        chk("R7 inverted open-drain", data_in, 32'hFF00FFFF);

        // R8: input gate applied before the inversion
        load_all(32'hFFFF0000, 32'hFF00FF00, '1, '0, '1, '0, 32'h87654321);
        chk("R8 gated input", data_in, 32'hFF9A4300);

        // R10: push-pull readback ignores inversion
        load_all(32'h6789ABCD, 32'h56789ABC, '1, '0, '0, '1, '1);
        chk("R10 readback equals drive", data_in, 32'h56789ABC);

        // R3 / R4: set and clear addresses
        load_all('0, '0, 32'h3456789A, '0, '0, '1, '1);
        wr(A_OCLR, 32'h00030002);
        rd(A_OE, v);   chk("R4 enable clear", v, 32'h34547898);
        chk("R4 enable clear pads", pad_level, '0);
        wr(A_OSET, 32'h0000F001);
        rd(A_OE, v);   chk("R3 enable set", v, 32'h3454F899);
        wr(A_DSET, 32'h00008200);
        rd(A_DOUT, v); chk("R3 drive set", v, 32'h00008200);
        chk("R3 drive set pads", pad_level, 32'h00008000);
        wr(A_DCLR, 32'h00008001);
        rd(A_DOUT, v); chk("R4 drive clear", v, 32'h00000200);

        // R9: writing the input address changes nothing
        load_all(32'h0000FFFF, 32'h12345678, 32'hFF00FF00, 32'h0F0F0F0F, 32'hAAAAAAAA, 32'h55555555, 32'hF0F0F0F0);
        pv = data_in;
        wr(A_DIN, 32'hDEADBEEF);
        chk("R9 write ignored, input", data_in, pv);
        rd(A_DOUT, v); chk("R9 write ignored, drive", v, 32'h12345678);
        rd(A_IE, v);   chk("R9 write ignored, gate", v, 32'hF0F0F0F0);

        // R11: unmapped and alias addresses read zero
        rd(A_DSET, v); chk("R11 set alias reads zero", v, '0);
        rd(A_OCLR, v); chk("R11 clear alias reads zero", v, '0);
        rd(7'h00, v);  chk("R11 address 0 reads zero", v, '0);
        rd(7'h7C, v);  chk("R11 top address reads zero", v, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule